// File: doc/BRIEF.md
# Transfer Descriptor Chain Builder

This block turns one transmit or receive request into a linked list of transfer descriptors in memory. A request gives a buffer start address, a byte count, a device address, an endpoint number, a direction flag and the endpoint's largest packet size. The block cuts the buffer into packet-sized pieces. It writes one four-word descriptor per piece and then appends an inactive terminator descriptor. Descriptors go to consecutive 16-byte slots that begin at a pool base address. All writes leave through a one-word write stream.

When the last word has been accepted, the block raises `done`. It presents the head descriptor address, which software anchors under the endpoint's queue head, and the total descriptor count. It takes no further request until `done_ack` has been seen. The request port and the write port are valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A write word is consumed on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the block holds the offered word unchanged and does not drop it.

Top module: `td_chain_builder`

## Requirements
- R1: After reset `req_ready` is 1, while `wr_valid` and `done` are 0.
- R2: A request of L bytes with packet size M (M ≥ 1) yields D = max(1, ceil(L/M)) data descriptors followed by one terminator, and `desc_count` reports D+1.
- R3: The token word bits [31:21] hold (piece length − 1) modulo 2048. Every data descriptor except the final one carries a piece length of M, and the final one carries the remaining bytes.
- R4: The buffer word of data descriptor i (counting from 0) equals start + i·M.
- R5: Descriptor i sits at B + 16·i, where B is `pool_base` with its low four bits cleared. Its words are written in the order link, control, token, buffer at offsets +0, +4, +8, +12. The link word of each data descriptor equals the address of the next descriptor, with bit 0 clear.
- R6: The control word of a data descriptor is 0x0080_0000, which is the active flag at bit 23. The token word carries the endpoint in bits [18:15], the device address in bits [14:8], and in bits [7:0] the packet identifier 0x69 for receive (`req_dir_in`=1) or 0xE1 for transmit. Bits [20:19] are zero.
- R7: The terminator descriptor has link word 0x0000_0001 (terminate flag set) and zero control, token and buffer words.
- R8: A zero-length request gives exactly one data descriptor with length code 0x7FF and buffer word equal to start, followed by the terminator.
- R9: Each descriptor word is offered once on the write stream. While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` stay stable.
- R10: `done` rises after the final word is accepted and holds, with `head_addr` = B and `desc_count`, until `done_ack`. From request acceptance until the cycle after `done_ack`, `req_ready` is 0, and a presented request starts no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_start | input | 32 | Buffer start address |
| req_len | input | LEN_W | Byte count |
| req_mps | input | MPS_W | Endpoint packet size (0 treated as 1) |
| req_dev | input | 7 | Device address |
| req_ep | input | 4 | Endpoint number |
| req_dir_in | input | 1 | 1 = receive, 0 = transmit |
| pool_base | input | 32 | Descriptor pool base (low 4 bits ignored) |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | Memory accepts the word |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Word value |
| done | output | 1 | Chain complete |
| done_ack | input | 1 | Acknowledges done |
| head_addr | output | 32 | First descriptor address |
| desc_count | output | CNT_W | Descriptors written, terminator included |

## Verification
The first write word is offered in the cycle after request acceptance. Each later word is offered in the cycle after the previous word's handshake. `done` rises in the cycle after the final handshake, and `req_ready` returns in the cycle after `done_ack` is sampled. The bench drives inputs shortly after the rising edge and samples every output at the falling edge. It logs each handshake there and compares the logged words with computed words only once `done` is seen. Because of this, random stalls on `wr_ready` do not shift any expected value.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int TD_AW       = 32;
  localparam int TD_LENF_W   = 11;
  localparam int TD_DEV_W    = 7;
  localparam int TD_EP_W     = 4;
  localparam int TD_WORDS    = 4;
  localparam logic [7:0] PID_IN  = 8'h69;
  localparam logic [7:0] PID_OUT = 8'hE1;
  localparam logic [31:0] CTRL_ACTIVE = 32'h0080_0000;
  localparam logic [31:0] LINK_END    = 32'h0000_0001;

  typedef enum logic [1:0] {W_LINK = 2'd0, W_CTRL = 2'd1, W_TOKEN = 2'd2, W_BUF = 2'd3} word_sel_e;
  typedef enum logic [1:0] {S_IDLE, S_EMIT, S_DONE} state_e;

  function automatic logic [31:0] make_token(input logic [TD_LENF_W-1:0] lcode,
                                             input logic [TD_EP_W-1:0] ep,
                                             input logic [TD_DEV_W-1:0] dev,
                                             input logic dir_in);
    return {lcode, 2'b00, ep, dev, (dir_in ? PID_IN : PID_OUT)};
  endfunction
endpackage

// File: rtl/td_segmenter.sv
module td_segmenter
  import td_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TD_AW-1:0]  start,
  input  logic [LEN_W-1:0]  len,
  input  logic [MPS_W-1:0]  mps,
  input  logic              advance,
  output logic [MPS_W-1:0]  seg_len,
  output logic [TD_AW-1:0]  bufptr,
  output logic              is_dummy,
  output logic [CNT_W-1:0]  idx
);
  localparam int CW = ((LEN_W > MPS_W) ? LEN_W : MPS_W) + 1;

  logic [LEN_W-1:0] rem;
  logic [MPS_W-1:0] mps_q;
  logic             last;

  assign last    = (CW'(rem) <= CW'(mps_q));
  assign seg_len = last ? MPS_W'(rem) : mps_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem      <= '0;
      mps_q    <= MPS_W'(1);
      bufptr   <= '0;
      is_dummy <= 1'b0;
      idx      <= '0;
    end else if (load) begin
      rem      <= len;
      mps_q    <= (mps == '0) ? MPS_W'(1) : mps;
      bufptr   <= start;
      is_dummy <= 1'b0;
      idx      <= '0;
    end else if (advance) begin
      idx <= idx + CNT_W'(1);
      if (last) begin
        is_dummy <= 1'b1;
      end else begin
        rem    <= rem - LEN_W'(mps_q);
        bufptr <= bufptr + TD_AW'(mps_q);
      end
    end
  end

  // R3: a data piece never exceeds the packet size
  assert_seg_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dummy |-> (seg_len <= mps_q));
  // R2: an advance on the final piece always leads to the terminator
  assert_last_to_dummy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && last && !is_dummy) |=> is_dummy);
endmodule

// File: rtl/td_word_mux.sv
module td_word_mux
  import td_pkg::*;
#(
  parameter int MPS_W = 11
) (
  input  word_sel_e             sel,
  input  logic                  is_dummy,
  input  logic [TD_AW-1:0]      next_addr,
  input  logic [MPS_W-1:0]      seg_len,
  input  logic [TD_AW-1:0]      bufptr,
  input  logic [TD_DEV_W-1:0]   dev,
  input  logic [TD_EP_W-1:0]    ep,
  input  logic                  dir_in,
  output logic [31:0]           word
);
  localparam int XW = (MPS_W > TD_LENF_W) ? MPS_W : TD_LENF_W;

  logic [XW-1:0]        len_m1;
  logic [TD_LENF_W-1:0] lcode;
  logic [31:0]          data_words [TD_WORDS];

  assign len_m1 = XW'(seg_len) - XW'(1);
  assign lcode  = len_m1[TD_LENF_W-1:0];

  assign data_words[W_LINK]  = next_addr;
  assign data_words[W_CTRL]  = CTRL_ACTIVE;
  assign data_words[W_TOKEN] = make_token(lcode, ep, dev, dir_in);
  assign data_words[W_BUF]   = bufptr;

  always_comb begin
    if (is_dummy) word = (sel == W_LINK) ? LINK_END : 32'h0;
    else          word = data_words[sel];
  end
endmodule

// File: rtl/td_chain_builder.sv
module td_chain_builder
  import td_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_start,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MPS_W-1:0]     req_mps,
  input  logic [6:0]           req_dev,
  input  logic [3:0]           req_ep,
  input  logic                 req_dir_in,
  input  logic [31:0]          pool_base,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [31:0]          wr_addr,
  output logic [31:0]          wr_data,
  output logic                 done,
  input  logic                 done_ack,
  output logic [31:0]          head_addr,
  output logic [CNT_W-1:0]     desc_count
);
  localparam logic [TD_AW-1:0] SLOT_BYTES = TD_AW'(TD_WORDS * 4);

  state_e               state;
  word_sel_e            wsel;
  logic [TD_AW-1:0]     base_q;
  logic [TD_DEV_W-1:0]  dev_q;
  logic [TD_EP_W-1:0]   ep_q;
  logic                 dir_q;
  logic                 accept, load, advance, wr_fire, desc_end;
  logic [MPS_W-1:0]     seg_len;
  logic [TD_AW-1:0]     bufptr, cur_addr, next_addr;
  logic                 is_dummy;
  logic [CNT_W-1:0]     idx;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign load      = accept;
  assign wr_valid  = (state == S_EMIT);
  assign wr_fire   = wr_valid && wr_ready;
  assign desc_end  = wr_fire && (wsel == W_BUF);
  assign advance   = desc_end && !is_dummy;
  assign done      = (state == S_DONE);

  assign cur_addr  = base_q + TD_AW'({idx, 4'b0000});
  assign next_addr = cur_addr + SLOT_BYTES;
  assign wr_addr   = cur_addr + TD_AW'({wsel, 2'b00});
  assign head_addr = base_q;
  assign desc_count = idx + CNT_W'(1);

  td_segmenter #(.LEN_W(LEN_W), .MPS_W(MPS_W), .CNT_W(CNT_W)) u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .start    (req_start),
    .len      (req_len),
    .mps      (req_mps),
    .advance  (advance),
    .seg_len  (seg_len),
    .bufptr   (bufptr),
    .is_dummy (is_dummy),
    .idx      (idx)
  );

  td_word_mux #(.MPS_W(MPS_W)) u_mux (
    .sel       (wsel),
    .is_dummy  (is_dummy),
    .next_addr (next_addr),
    .seg_len   (seg_len),
    .bufptr    (bufptr),
    .dev       (dev_q),
    .ep        (ep_q),
    .dir_in    (dir_q),
    .word      (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wsel   <= W_LINK;
      base_q <= '0;
      dev_q  <= '0;
      ep_q   <= '0;
      dir_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_EMIT;
          wsel   <= W_LINK;
          base_q <= pool_base & ~TD_AW'(15);
          dev_q  <= req_dev;
          ep_q   <= req_ep;
          dir_q  <= req_dir_in;
        end
        S_EMIT: if (wr_fire) begin
          wsel <= word_sel_e'(wsel + 2'd1);
          if (desc_end && is_dummy) state <= S_DONE;
        end
        S_DONE: if (done_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: a stalled word is held unchanged
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R5: word addresses stay word aligned
  assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));
  // R10: done holds with its results until acknowledged
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ack) |=> (done && $stable(head_addr) && $stable(desc_count)));
  // R10: no request accepted and no write while busy or done
  assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || wr_valid) |-> !req_ready);
  // R10: done only follows a write handshake or holds
  assert_done_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_fire));
endmodule

// File: tb/tb_td_chain_builder.sv
module tb_td_chain_builder;
  localparam int LEN_W = 16;
  localparam int MPS_W = 11;
  localparam int CNT_W = LEN_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_start = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [MPS_W-1:0] req_mps = '0;
  logic [6:0] req_dev = '0;
  logic [3:0] req_ep = '0;
  logic req_dir_in = 1'b0;
  logic [31:0] pool_base = '0;
  logic wr_valid;
  logic wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data;
  logic done;
  logic done_ack = 1'b0;
  logic [31:0] head_addr;
  logic [CNT_W-1:0] desc_count;

  int checks = 0;
  int errors = 0;
  bit stall_en = 1'b0;
  bit finished = 1'b0;
  logic [31:0] qa[$];
  logic [31:0] qd[$];

  always #2 clk = ~clk;

  td_chain_builder #(.LEN_W(LEN_W), .MPS_W(MPS_W)) dut (.*);

  always @(posedge clk) begin
    #1 wr_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      qa.push_back(wr_addr);
      qd.push_back(wr_data);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] st, input int len, input int mps,
      input int dev, input int ep, input bit din, input logic [31:0] b, input int i, input int n, input int w);
    int plen;
    logic [31:0] tok;
    if (i == n) return (w == 0) ? 32'h1 : 32'h0;
    plen = (i < n - 1) ? mps : (len - (n - 1) * mps);
    tok = {11'(plen - 1), 2'b00, 4'(ep), 7'(dev), (din ? 8'h69 : 8'hE1)};
    case (w)
      0: return b + 32'((i + 1) * 16);
      1: return 32'h0080_0000;
      2: return tok;
      default: return st + 32'(i * mps);
    endcase
  endfunction

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b1;
    @(negedge clk);
    while (!done) begin
      n++;
      if (n > 20000) begin ok = 1'b0; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_req(input logic [31:0] st, input int len, input int mps, input int dev,
                         input int ep, input bit din, input logic [31:0] pb, input string tag);
    int n, nw;
    bit ok;
    logic [31:0] b;
    n = (len == 0) ? 1 : (len + mps - 1) / mps;
    b = pb & ~32'hF;
    qa.delete(); qd.delete();
    @(negedge clk);
    req_start = st; req_len = LEN_W'(len); req_mps = MPS_W'(mps);
    req_dev = 7'(dev); req_ep = 4'(ep); req_dir_in = din; pool_base = pb;
    req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    wait_done(ok);
    chk(ok, {"R10 done timeout ", tag}, 32'(done), 32'h1);
    if (!ok) return;
    chk(desc_count == CNT_W'(n + 1), {"R2 desc_count ", tag}, 32'(desc_count), 32'(n + 1));
    chk(head_addr == b, {"R10/R5 head_addr ", tag}, head_addr, b);
    nw = 4 * (n + 1);
    chk(qa.size() == nw, {"R9 word count ", tag}, 32'(qa.size()), 32'(nw));
    if (qa.size() == nw) begin
      for (int k = 0; k < nw; k++) begin
        logic [31:0] ea, ed;
        ea = b + 32'(k * 4);
        ed = exp_word(st, len, mps, dev, ep, din, b, k / 4, n, k % 4);
        chk(qa[k] == ea, {"R5 addr ", tag}, qa[k], ea);
        if (k / 4 == n) chk(qd[k] == ed, {"R7 terminator ", tag}, qd[k], ed);
        else if (k % 4 == 2) chk(qd[k] == ed, {"R3/R6 token ", tag}, qd[k], ed);
        else if (k % 4 == 3) chk(qd[k] == ed, {"R4 buffer ", tag}, qd[k], ed);
        else chk(qd[k] == ed, {"R5/R6 link/ctrl ", tag}, qd[k], ed);
      end
    end
    // R10: a request presented while done is ignored
    req_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!req_ready && !wr_valid && done, {"R10 held off ", tag}, {30'b0, req_ready, wr_valid}, 32'h0);
    end
    req_valid = 1'b0;
    chk(qa.size() == nw, {"R10 no extra writes ", tag}, 32'(qa.size()), 32'(nw));
    done_ack = 1'b1;
    @(posedge clk); #1 done_ack = 1'b0;
    @(negedge clk);
    chk(!done && req_ready, {"R10 ack release ", tag}, {30'b0, done, req_ready}, 32'h1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && wr_valid == 1'b0 && done == 1'b0, "R1 reset",
        {29'b0, req_ready, wr_valid, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && wr_valid == 1'b0 && done == 1'b0, "R1 after reset",
        {29'b0, req_ready, wr_valid, done}, 32'h4);
    run_req(32'h1000_0000, 0,   64,  5, 2, 1'b0, 32'h0000_8000, "R8 zero length");
    run_req(32'h2000_0010, 64,  64,  9, 1, 1'b1, 32'h0000_9007, "R3 exact packet");
    run_req(32'h2000_0100, 65,  64,  9, 1, 1'b1, 32'h0000_A000, "R3 one over");
    run_req(32'h3000_0000, 5,   1,   3, 15, 1'b0, 32'h0000_B00F, "R2 unit packets");
    run_req(32'h3000_0400, 30,  1023, 127, 7, 1'b1, 32'h0000_C000, "R3 short");
    run_req(32'h3000_0800, 2046, 1023, 1, 3, 1'b0, 32'h0000_D000, "R3 max packet");
    stall_en = 1'b1;
    run_req(32'h4000_0000, 200, 32,  12, 4, 1'b1, 32'h0001_0003, "R9 stalled");
    for (int r = 0; r < 30; r++) begin
      int len, mps;
      len = int'($urandom % 2000);
      mps = 16 + int'($urandom % 1008);
      stall_en = (($urandom % 2) == 1);
      run_req($urandom, len, mps, int'($urandom % 128), int'($urandom % 16),
              1'($urandom % 2), $urandom, "random");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule